// File: doc/BRIEF.md
# Translation Fill Permission Checker

This block sits between a page-table walker and the data translation buffer. For each fetched page table entry it takes the faulting virtual address, whether the processor is in user or kernel mode, and whether the access was a read or a write. It then decides whether the entry may be installed. When the entry passes, the block issues a fill: a buffer tag write and an entry data write. When the entry fails, it gives the exception logic a memory-management fault code and a flag that says whether a write caused the fault.

The entry is tested with a fixed precedence. First comes the mode- and direction-specific enable bit, then the valid bit, and last the fault-on-access bit that matches the direction. The block checks one request in a single cycle. The result is registered and reported as a one-cycle pulse.

Top module: `ptePermCheck`

## Requirements
- R1: After reset, fillValid and faultValid are 0 and faultCode is 2'b00.
- R2: The enable bit that is tested depends on the access. A kernel write tests entry bit 12 and a user write tests bit 13. A kernel read tests bit 8 and a user read tests bit 9. If the tested bit is clear, faultCode is 2'b01 (access violation), even when the enable bit for the other mode or direction is set.
- R3: If the tested enable bit is set and valid (entry bit 0) is clear, faultCode is 2'b10 (not valid).
- R4: If enable and valid both pass, a write with fault-on-write (bit 2) set reports faultCode 2'b11, and a read with fault-on-read (bit 1) set also reports 2'b11. A write ignores bit 1 and a read ignores bit 2.
- R5: When several fault conditions hold together, access violation takes precedence over not valid, and not valid takes precedence over fault-on-access.
- R6: When no fault applies, fillValid pulses, fillTag equals the virtual address shifted right by 13, and fillData equals the entry.
- R7: With every fault, faultWrite is 1 for a write access and 0 for a read access.
- R8: Each accepted request produces exactly one of fillValid or faultValid. The pulse lasts one cycle and appears in the cycle after the request. No pulse appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqPte | input | 64 | Fetched page table entry |
| reqVaddr | input | 64 | Faulting virtual address |
| reqUserMode | input | 1 | 1 = user mode, 0 = kernel mode |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| fillValid | output | 1 | One-cycle fill strobe |
| fillTag | output | 51 | Buffer tag (virtual address >> 13) |
| fillData | output | 64 | Entry to install |
| faultValid | output | 1 | One-cycle fault strobe |
| faultCode | output | 2 | 01 access violation, 10 not valid, 11 fault on access |
| faultWrite | output | 1 | Fault was caused by a write |

## Verification
Every result goes through a single register stage. A request held across a rising edge therefore shows up on the outputs during the cycle after that edge, and the pulse is gone one edge later. The bench drives each request on a falling edge. It reads the outputs at the next falling edge, where the pulse should be present, and again one falling edge later, where it should have cleared. Idle cycles are checked the same way, to confirm that no pulse appears.

// File: rtl/ptePermPkg.sv
package ptePermPkg;
  typedef enum logic [1:0] {
    FAULT_NONE    = 2'b00,
    FAULT_ACCESS  = 2'b01,
    FAULT_INVALID = 2'b10,
    FAULT_ONUSE   = 2'b11
  } faultCode_e;

  localparam int BIT_VALID = 0;
  localparam int BIT_FOR   = 1;
  localparam int BIT_FOW   = 2;
  localparam int BIT_KRE   = 8;
  localparam int BIT_URE   = 9;
  localparam int BIT_KWE   = 12;
  localparam int BIT_UWE   = 13;

  typedef struct packed {
    logic uwe;
    logic kwe;
    logic ure;
    logic kre;
    logic fow;
    logic forBit;
    logic valid;
  } pteFlags_t;

  typedef struct packed {
    logic loadFill;
    logic loadFault;
  } strobes_t;
endpackage

// File: rtl/ptePermCtrl.sv
module ptePermCtrl
  import ptePermPkg::*;
(
  input  logic       reqValid,
  input  pteFlags_t  flags,
  input  logic       reqUserMode,
  input  logic       reqWrite,
  output strobes_t   strobes,
  output faultCode_e nextCode
);
  logic readEn;
  logic writeEn;
  logic enOk;
  logic onUseBit;

  always_comb begin
    readEn   = reqUserMode ? flags.ure : flags.kre;
    writeEn  = reqUserMode ? flags.uwe : flags.kwe;
    enOk     = reqWrite ? writeEn : readEn;
    onUseBit = reqWrite ? flags.fow : flags.forBit;
    if (!enOk)             nextCode = FAULT_ACCESS;
    else if (!flags.valid) nextCode = FAULT_INVALID;
    else if (onUseBit)     nextCode = FAULT_ONUSE;
    else                   nextCode = FAULT_NONE;
    strobes.loadFault = reqValid && (nextCode != FAULT_NONE);
    strobes.loadFill  = reqValid && (nextCode == FAULT_NONE);
  end
endmodule

// File: rtl/ptePermDatapath.sv
module ptePermDatapath
  import ptePermPkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 13,
  localparam int TAG_W     = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strobes,
  input  faultCode_e       nextCode,
  input  logic             reqValid,
  input  logic [PTE_W-1:0] reqPte,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqUserMode,
  input  logic             reqWrite,
  output logic             fillValid,
  output logic [TAG_W-1:0] fillTag,
  output logic [PTE_W-1:0] fillData,
  output logic             faultValid,
  output logic [1:0]       faultCode,
  output logic             faultWrite
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillValid  <= 1'b0;
      faultValid <= 1'b0;
      fillTag    <= '0;
      fillData   <= '0;
      faultCode  <= 2'b00;
      faultWrite <= 1'b0;
    end else begin
      fillValid  <= strobes.loadFill;
      faultValid <= strobes.loadFault;
      if (strobes.loadFill) begin
        fillTag  <= TAG_W'(reqVaddr >> PAGE_SHIFT);
        fillData <= reqPte;
      end
      if (strobes.loadFault) begin
        faultCode  <= nextCode;
        faultWrite <= reqWrite;
      end
    end
  end

  assert_one_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fillValid, faultValid}));

  assert_pulse_needs_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid || faultValid) |-> $past(reqValid));

  assert_fill_tag_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> (fillTag == TAG_W'($past(reqVaddr) >> PAGE_SHIFT)) && (fillData == $past(reqPte)));

  assert_write_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> faultWrite == $past(reqWrite));

  assert_invalid_code_R3: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode == 2'b10) |-> !$past(reqPte[BIT_VALID]));

  assert_fill_clean_R4: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $past(reqPte[BIT_VALID]) &&
                  !$past(reqWrite ? reqPte[BIT_FOW] : reqPte[BIT_FOR]));

  assert_enable_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && faultCode != 2'b01) |->
      $past(reqWrite ? (reqUserMode ? reqPte[BIT_UWE] : reqPte[BIT_KWE])
                     : (reqUserMode ? reqPte[BIT_URE] : reqPte[BIT_KRE])));
endmodule

// File: rtl/ptePermCheck.sv
module ptePermCheck
  import ptePermPkg::*;
#(
  parameter int VA_W       = 64,
  parameter int PTE_W      = 64,
  parameter int PAGE_SHIFT = 13,
  localparam int TAG_W     = VA_W - PAGE_SHIFT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [PTE_W-1:0] reqPte,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqUserMode,
  input  logic             reqWrite,
  output logic             fillValid,
  output logic [TAG_W-1:0] fillTag,
  output logic [PTE_W-1:0] fillData,
  output logic             faultValid,
  output logic [1:0]       faultCode,
  output logic             faultWrite
);
  pteFlags_t  flags;
  strobes_t   strobes;
  faultCode_e nextCode;

  assign flags = '{uwe:    reqPte[BIT_UWE], kwe: reqPte[BIT_KWE],
                   ure:    reqPte[BIT_URE], kre: reqPte[BIT_KRE],
                   fow:    reqPte[BIT_FOW], forBit: reqPte[BIT_FOR],
                   valid:  reqPte[BIT_VALID]};

  ptePermCtrl i_ctrl (
    .reqValid    (reqValid),
    .flags       (flags),
    .reqUserMode (reqUserMode),
    .reqWrite    (reqWrite),
    .strobes     (strobes),
    .nextCode    (nextCode)
  );

  ptePermDatapath #(
    .VA_W(VA_W), .PTE_W(PTE_W), .PAGE_SHIFT(PAGE_SHIFT)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .nextCode    (nextCode),
    .reqValid    (reqValid),
    .reqPte      (reqPte),
    .reqVaddr    (reqVaddr),
    .reqUserMode (reqUserMode),
    .reqWrite    (reqWrite),
    .fillValid   (fillValid),
    .fillTag     (fillTag),
    .fillData    (fillData),
    .faultValid  (faultValid),
    .faultCode   (faultCode),
    .faultWrite  (faultWrite)
  );
endmodule

// File: tb/test_ptePermCheck.sv
module test_ptePermCheck;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqPte = '0;
  logic [63:0] reqVaddr = '0;
  logic        reqUserMode = 1'b0;
  logic        reqWrite = 1'b0;
  logic        fillValid;
  logic [50:0] fillTag;
  logic [63:0] fillData;
  logic        faultValid;
  logic [1:0]  faultCode;
  logic        faultWrite;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptePermCheck i_ptePermCheck (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPte(reqPte),
    .reqVaddr(reqVaddr), .reqUserMode(reqUserMode), .reqWrite(reqWrite),
    .fillValid(fillValid), .fillTag(fillTag), .fillData(fillData),
    .faultValid(faultValid), .faultCode(faultCode), .faultWrite(faultWrite)
  );

  function automatic logic [63:0] mkPte(bit v, bit fr, bit fw, bit kre, bit ure, bit kwe, bit uwe);
    logic [63:0] p = 64'hABCD_0000_0000_0000;
    p[0] = v; p[1] = fr; p[2] = fw; p[8] = kre; p[9] = ure; p[12] = kwe; p[13] = uwe;
    return p;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, result visible at the following falling edge
  task automatic issue(logic [63:0] pte, logic [63:0] va, bit user, bit wr);
    reqValid = 1'b1; reqPte = pte; reqVaddr = va; reqUserMode = user; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectFault(string req, logic [63:0] pte, logic [63:0] va, bit user, bit wr, logic [1:0] code);
    issue(pte, va, user, wr);
    chk(req, "faultValid", 64'(faultValid), 64'd1);
    chk(req, "fillValid", 64'(fillValid), 64'd0);
    chk(req, "faultCode", 64'(faultCode), 64'(code));
    chk("R7", "faultWrite", 64'(faultWrite), 64'(wr));
    @(negedge clk);
    chk("R8", "fault pulse cleared", 64'(faultValid), 64'd0);
  endtask

  task automatic expectFill(string req, logic [63:0] pte, logic [63:0] va, bit user, bit wr);
    issue(pte, va, user, wr);
    chk(req, "fillValid", 64'(fillValid), 64'd1);
    chk(req, "faultValid", 64'(faultValid), 64'd0);
    chk("R6", "fillTag", 64'(fillTag), va >> 13);
    chk("R6", "fillData", fillData, pte);
    @(negedge clk);
    chk("R8", "fill pulse cleared", 64'(fillValid), 64'd0);
  endtask

  task automatic testReset();
    chk("R1", "fillValid", 64'(fillValid), 64'd0);
    chk("R1", "faultValid", 64'(faultValid), 64'd0);
    chk("R1", "faultCode", 64'(faultCode), 64'd0);
  endtask

  task automatic testEnableSelect();
    // each case: only the non-selected enables set, valid and clean -> access violation
    expectFault("R2", mkPte(1,0,0,1,1,0,1), 64'h1000, 0, 1, 2'b01); // kernel write, bit12 clear
    expectFault("R2", mkPte(1,0,0,1,1,1,0), 64'h2000, 1, 1, 2'b01); // user write, bit13 clear
    expectFault("R2", mkPte(1,0,0,0,1,1,1), 64'h3000, 0, 0, 2'b01); // kernel read, bit8 clear
    expectFault("R2", mkPte(1,0,0,1,0,1,1), 64'h4000, 1, 0, 2'b01); // user read, bit9 clear
    expectFill("R2", mkPte(1,0,0,0,0,1,0), 64'h5000, 0, 1);          // kernel write, only bit12
    expectFill("R2", mkPte(1,0,0,0,1,0,0), 64'h6000, 1, 0);          // user read, only bit9
  endtask

  task automatic testNotValid();
    expectFault("R3", mkPte(0,0,0,1,1,1,1), 64'h7000, 0, 0, 2'b10);
    expectFault("R3", mkPte(0,0,0,1,1,1,1), 64'h8000, 1, 1, 2'b10);
  endtask

  task automatic testOnUse();
    expectFault("R4", mkPte(1,0,1,1,1,1,1), 64'h9000, 1, 1, 2'b11); // write, FOW
    expectFault("R4", mkPte(1,1,0,1,1,1,1), 64'hA000, 0, 0, 2'b11); // read, FOR
    expectFill("R4", mkPte(1,1,0,1,1,1,1), 64'hB000, 0, 1);         // write ignores FOR
    expectFill("R4", mkPte(1,0,1,1,1,1,1), 64'hC000, 1, 0);         // read ignores FOW
  endtask

  task automatic testPriority();
    expectFault("R5", mkPte(0,1,1,0,0,0,0), 64'hD000, 0, 1, 2'b01);
    expectFault("R5", mkPte(0,1,1,0,0,0,0), 64'hE000, 1, 0, 2'b01);
    expectFault("R5", mkPte(0,1,1,1,1,1,1), 64'hF000, 1, 1, 2'b10);
    expectFault("R5", mkPte(0,1,1,1,1,1,1), 64'h10000, 0, 0, 2'b10);
  endtask

  task automatic testFill();
    expectFill("R6", mkPte(1,0,0,1,1,1,1), 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);
    expectFill("R6", mkPte(1,0,0,1,1,1,1), 64'h0000_0000_0000_1FFF, 0, 0);
    expectFill("R6", mkPte(1,0,0,1,1,1,1) | 64'h00F0, 64'h1234_5678_9ABC_DEF0, 0, 1);
  endtask

  task automatic testIdle();
    reqPte = mkPte(1,0,0,1,1,1,1); reqVaddr = 64'h4242_0000; reqValid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8", "no fill without request", 64'(fillValid), 64'd0);
      chk("R8", "no fault without request", 64'(faultValid), 64'd0);
    end
    // back-to-back: fault then fill on consecutive cycles
    reqValid = 1'b1; reqPte = mkPte(0,0,0,1,1,1,1); reqVaddr = 64'h2_0000; reqUserMode = 0; reqWrite = 0;
    @(negedge clk);
    chk("R8", "b2b faultValid", 64'(faultValid), 64'd1);
    chk("R7", "b2b read faultWrite", 64'(faultWrite), 64'd0);
    reqPte = mkPte(1,0,0,1,1,1,1); reqVaddr = 64'h4_0000;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8", "b2b fillValid", 64'(fillValid), 64'd1);
    chk("R8", "b2b fault cleared", 64'(faultValid), 64'd0);
    chk("R6", "b2b fillTag", 64'(fillTag), 64'h20);
    @(negedge clk);
    chk("R8", "b2b fill cleared", 64'(fillValid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testEnableSelect();
    testNotValid();
    testOnUse();
    testPriority();
    testFill();
    testIdle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule